// File: doc/BRIEF.md
# Shared Bank Front-End with Two Open-Row Buffers

This block sits in front of one single-ported memory bank of a processing-in-memory chip. Three requesters compete for it: the local processing element and the elements on its left and right along a ring. A round-robin arbiter picks one request at a time. The grant stays with that requester until its access completes. The bank keeps two open-row buffers of one row each. Any access is served from a buffer. A request whose row is already open in either buffer is a hit. Otherwise the least-recently-used buffer is refilled from the array, and it is written back first if it holds modified data.

Each requester holds `valid` high together with its address, data, write flag and byte enables until the block pulses its `ready` bit. That pulse marks completion. A read also returns its data in that same cycle, tagged with the requester number. The storage array is a behavioural register array of `ARR_ROWS` rows. A row number above that count folds onto array row `tag mod ARR_ROWS`.

Top module: `bank_front_end`

## Requirements
- R1: At most one `req_ready` bit is high in any cycle. No new request is accepted while one is in service. `req_ready[i]` goes high only while `req_valid[i]` is high.
- R2: When several requesters are valid, the next grant goes to the first valid requester after the last one served, in the order 0, 1, 2, wrapping. After reset the last one served counts as requester 2, so requester 0 wins first.
- R3: The edge that accepts a request is the first edge at which the block is idle and the request's valid is high. Address bits [10:2] pick the word inside a row and bits [19:11] form the row tag. A request whose tag is open in either buffer raises `req_ready` 4 cycles after that edge. The handshake completes on the edge after that.
- R4: A request whose tag is in neither buffer, and whose replaced buffer is invalid or clean, raises `req_ready` 8 cycles after the accepting edge.
- R5: A miss that replaces a buffer holding written data raises `req_ready` 12 cycles after the accepting edge. That data is written back to the array first, so it is not lost.
- R6: A read raises `rsp_valid` for exactly one cycle, in the same cycle as its `req_ready`. In that cycle `rsp_id` holds the requester number and `rsp_rdata` the addressed word. A write never raises `rsp_valid`.
- R7: A write changes only the bytes whose enable bit is set. Enable bit b covers data bits [8b+7:8b]. A later read of that word returns the merged value.
- R8: After reset both buffers are invalid and the replacement pointer selects buffer 0. On a miss the buffer not used by the most recent access is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 3 | Request valid, one bit per requester |
| req_ready | output | 3 | Completion pulse, one bit per requester |
| req_addr | input | 60 | Byte addresses, requester i in bits [20i+19:20i] |
| req_wdata | input | 96 | Write data, requester i in bits [32i+31:32i] |
| req_we | input | 3 | Write flag per requester |
| req_be | input | 12 | Byte enables, requester i in bits [4i+3:4i] |
| rsp_valid | output | 1 | Read data valid |
| rsp_id | output | 2 | Requester that the read data belongs to |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that a requester keeps its valid and request fields steady from the moment it raises valid until its ready pulse. They also assume that it then drops valid, or presents a new request, only after the completing edge. The bench drives every request at a falling edge and waits for its own ready bit. It lowers valid at the falling edge after the handshake, so the accepted fields never change under the block. Random addresses use only tags below the array row count, so the bench memory model never sees folded rows.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

  // Service time of one access, counted from the accepting edge to ready.
  function automatic int svc_cycles(bit hit, bit dirty_victim,
                                    int hit_c, int miss_c, int wb_c);
    if (hit) return hit_c;
    return miss_c + (dirty_victim ? wb_c : 0);
  endfunction

  // Next requester after 'last' in cyclic order, among the set bits of 'req'.
  function automatic int rr_next(logic [31:0] req, int last, int n);
    for (int k = 1; k <= n; k++) begin
      if (req[(last + k) % n]) return (last + k) % n;
    end
    return last;
  endfunction

endpackage

// File: rtl/bfe_rr_arb.sv
module bfe_rr_arb #(
  parameter int N_REQ = 3,
  localparam int ID_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req,
  input  logic [ID_W-1:0]  last,
  output logic             any,
  output logic [ID_W-1:0]  pick
);
  import bfe_pkg::*;

  logic [31:0] req_ext;

  always_comb begin
    req_ext = '0;
    req_ext[N_REQ-1:0] = req;
    any  = |req;
    pick = ID_W'(rr_next(req_ext, int'(last), N_REQ));
  end
endmodule

// File: rtl/bfe_row_store.sv
module bfe_row_store #(
  parameter int DATA_W   = 32,
  parameter int WORDS    = 512,
  parameter int ARR_ROWS = 4,
  localparam int COL_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(ARR_ROWS),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_en,
  input  logic              wb_way,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              fill_en,
  input  logic              fill_way,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic              rd_way,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rbuf [2][WORDS];
  logic [DATA_W-1:0] arr  [ARR_ROWS][WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ARR_ROWS; r++)
        for (int w = 0; w < WORDS; w++) arr[r][w] <= '0;
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < WORDS; w++) rbuf[b][w] <= '0;
    end else begin
      if (wb_en)
        for (int w = 0; w < WORDS; w++) arr[wb_idx][w] <= rbuf[wb_way][w];
      if (fill_en)
        for (int w = 0; w < WORDS; w++) rbuf[fill_way][w] <= arr[fill_idx][w];
      if (wr_en)
        for (int b = 0; b < BE_W; b++)
          if (wr_be[b]) rbuf[wr_way][wr_col][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
  end

  assign rd_data = rbuf[rd_way][rd_col];
endmodule

// File: rtl/bank_front_end.sv
module bank_front_end #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int N_REQ     = 3,
  parameter int ROW_BYTES = 2048,
  parameter int ARR_ROWS  = 4,
  parameter int HIT_CYC   = 4,
  parameter int MISS_CYC  = 8,
  parameter int WB_CYC    = 4,
  localparam int BE_W   = DATA_W / 8,
  localparam int BYTE_W = $clog2(BE_W),
  localparam int WORDS  = ROW_BYTES / BE_W,
  localparam int COL_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - COL_W - BYTE_W,
  localparam int IDX_W  = $clog2(ARR_ROWS),
  localparam int ID_W   = $clog2(N_REQ),
  localparam int CNT_W  = $clog2(MISS_CYC + WB_CYC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_valid,
  output logic [N_REQ-1:0]         req_ready,
  input  logic [N_REQ*ADDR_W-1:0]  req_addr,
  input  logic [N_REQ*DATA_W-1:0]  req_wdata,
  input  logic [N_REQ-1:0]         req_we,
  input  logic [N_REQ*BE_W-1:0]    req_be,
  output logic                     rsp_valid,
  output logic [ID_W-1:0]          rsp_id,
  output logic [DATA_W-1:0]        rsp_rdata
);
  import bfe_pkg::*;

  // Service state
  logic              busy, fill_pend, q_we, q_way;
  logic [ID_W-1:0]   gid, last_id;
  logic [CNT_W-1:0]  cnt;
  logic [COL_W-1:0]  q_col;
  logic [TAG_W-1:0]  q_tag;
  logic [DATA_W-1:0] q_wdata;
  logic [BE_W-1:0]   q_be;

  // Open-row bookkeeping
  logic [TAG_W-1:0]  tag_q [2];
  logic [1:0]        vld_q, dirty_q;
  logic              lru_q;

  // Arbitration
  logic              any_req;
  logic [ID_W-1:0]   pick;

  bfe_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .req (req_valid), .last(last_id), .any(any_req), .pick(pick)
  );

  logic [ADDR_W-1:0] sel_addr;
  logic [TAG_W-1:0]  sel_tag;
  logic [1:0]        way_hit;
  logic              hit, hit_way, vic_dirty;

  assign sel_addr  = req_addr[pick*ADDR_W +: ADDR_W];
  assign sel_tag   = sel_addr[ADDR_W-1 -: TAG_W];
  assign way_hit[0] = vld_q[0] && (tag_q[0] == sel_tag);
  assign way_hit[1] = vld_q[1] && (tag_q[1] == sel_tag);
  assign hit       = |way_hit;
  assign hit_way   = !way_hit[0];
  assign vic_dirty = vld_q[lru_q] && dirty_q[lru_q];

  // Named events for the checker
  logic grant_ev, miss_ev, wb_ev, done_ev;
  assign grant_ev = !busy && any_req;
  assign miss_ev  = grant_ev && !hit;
  assign wb_ev    = miss_ev && vic_dirty;
  assign done_ev  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; fill_pend <= 1'b0; cnt <= '0;
      gid <= '0; last_id <= ID_W'(N_REQ - 1);
      q_we <= 1'b0; q_way <= 1'b0; q_col <= '0; q_tag <= '0;
      q_wdata <= '0; q_be <= '0;
      vld_q <= '0; dirty_q <= '0; lru_q <= 1'b0;
      tag_q[0] <= '0; tag_q[1] <= '0;
    end else if (grant_ev) begin
      busy      <= 1'b1;
      gid       <= pick;
      q_tag     <= sel_tag;
      q_col     <= sel_addr[BYTE_W +: COL_W];
      q_we      <= req_we[pick];
      q_wdata   <= req_wdata[pick*DATA_W +: DATA_W];
      q_be      <= req_be[pick*BE_W +: BE_W];
      q_way     <= hit ? hit_way : lru_q;
      fill_pend <= !hit;
      cnt <= CNT_W'(svc_cycles(hit, vic_dirty, HIT_CYC, MISS_CYC, WB_CYC) - 1);
      if (!hit) begin
        tag_q[lru_q]   <= sel_tag;
        vld_q[lru_q]   <= 1'b1;
        dirty_q[lru_q] <= 1'b0;
      end
    end else if (busy) begin
      fill_pend <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (done_ev) begin
        busy    <= 1'b0;
        last_id <= gid;
        lru_q   <= !q_way;
        if (q_we) dirty_q[q_way] <= 1'b1;
      end
    end
  end

  logic [DATA_W-1:0] rd_data;

  bfe_row_store #(.DATA_W(DATA_W), .WORDS(WORDS), .ARR_ROWS(ARR_ROWS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_en   (wb_ev),
    .wb_way  (lru_q),
    .wb_idx  (tag_q[lru_q][IDX_W-1:0]),
    .fill_en (busy && fill_pend),
    .fill_way(q_way),
    .fill_idx(q_tag[IDX_W-1:0]),
    .wr_en   (done_ev && q_we),
    .wr_way  (q_way),
    .wr_col  (q_col),
    .wr_data (q_wdata),
    .wr_be   (q_be),
    .rd_way  (q_way),
    .rd_col  (q_col),
    .rd_data (rd_data)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_ready
    assign req_ready[i] = done_ev && (gid == ID_W'(i));
  end

  assign rsp_valid = done_ev && !q_we;
  assign rsp_id    = gid;
  assign rsp_rdata = rd_data;
endmodule

// File: rtl/bfe_checker.sv
module bfe_checker #(
  parameter int N_REQ    = 3,
  parameter int HIT_CYC  = 4,
  parameter int MISS_CYC = 8,
  parameter int WB_CYC   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req_valid,
  input logic [N_REQ-1:0] req_ready,
  input logic             rsp_valid,
  input logic             grant_ev,
  input logic             miss_ev,
  input logic             wb_ev,
  input logic             done_ev
);
  int  lat_cnt, lat_exp;
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= 0; lat_exp <= 0; open_q <= 1'b0;
    end else if (grant_ev) begin
      lat_cnt <= 1;
      lat_exp <= !miss_ev ? HIT_CYC : (wb_ev ? MISS_CYC + WB_CYC : MISS_CYC);
      open_q  <= 1'b1;
    end else begin
      lat_cnt <= lat_cnt + 1;
      if (done_ev) open_q <= 1'b0;
    end
  end

  p_one_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  p_ready_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  p_no_regrant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ev |-> !open_q);
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && open_q) |-> (lat_cnt == lat_exp));
  p_wb_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ev |-> miss_ev);
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (|req_ready));
endmodule

bind bank_front_end bfe_checker #(
  .N_REQ(N_REQ), .HIT_CYC(HIT_CYC), .MISS_CYC(MISS_CYC), .WB_CYC(WB_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .grant_ev(grant_ev), .miss_ev(miss_ev),
  .wb_ev(wb_ev), .done_ev(done_ev)
);

// File: tb/bank_front_end_bench.sv
module bank_front_end_bench;
  localparam int AW = 20, DW = 32, NR = 3, WORDS = 512, ROWS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] req_valid = '0, req_we = '0, req_ready;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR*DW-1:0] req_wdata = '0;
  logic [NR*4-1:0]  req_be = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_id;
  logic [DW-1:0] rsp_rdata;

  bank_front_end u_bank_front_end (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_rdata(rsp_rdata)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  // Reference model
  logic [DW-1:0] mem_m [ROWS*WORDS];
  int  m_tag [2];
  bit  m_vld [2], m_dirty [2];
  int  m_lru = 0, m_last = 2;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mk_addr(int tag, int col);
    return (tag << 11) | (col << 2);
  endfunction

  function automatic int exp_lat(int tag);
    if ((m_vld[0] && m_tag[0] == tag) || (m_vld[1] && m_tag[1] == tag)) return 4;
    return (m_vld[m_lru] && m_dirty[m_lru]) ? 12 : 8;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [3:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic model_access(int id, int tag, int col, bit we,
                              logic [DW-1:0] wd, logic [3:0] be);
    int way;
    if (m_vld[0] && m_tag[0] == tag) way = 0;
    else if (m_vld[1] && m_tag[1] == tag) way = 1;
    else begin
      way = m_lru; m_tag[way] = tag; m_vld[way] = 1; m_dirty[way] = 0;
    end
    if (we) begin
      m_dirty[way] = 1;
      mem_m[tag*WORDS + col] = merge(mem_m[tag*WORDS + col], wd, be);
    end
    m_lru = 1 - way;
    m_last = id;
  endtask

  task automatic single(int id, int tag, int col, bit we, logic [DW-1:0] wd,
                        logic [3:0] be, string rl);
    int lat = 0, elat;
    logic [DW-1:0] edat;
    elat = exp_lat(tag);
    edat = mem_m[tag*WORDS + col];
    @(negedge clk);
    req_addr[id*AW +: AW] = AW'(mk_addr(tag, col));
    req_wdata[id*DW +: DW] = wd;
    req_we[id] = we;
    req_be[id*4 +: 4] = be;
    req_valid[id] = 1'b1;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_ready[id] && lat < 40);
    chk(lat == elat, rl, lat, elat);
    if (!we) begin
      chk(rsp_valid && rsp_id == 2'(id), "R6 rsp_valid/rsp_id", {rsp_valid, rsp_id}, {1'b1, 2'(id)});
      chk(rsp_rdata == edat, "R7 read data", rsp_rdata, edat);
    end else begin
      chk(!rsp_valid, "R6 no response on write", rsp_valid, 0);
    end
    @(negedge clk);
    req_valid[id] = 1'b0;
    chk(!rsp_valid && req_ready == '0, "R6 single-cycle pulse", {rsp_valid, req_ready}, 0);
    model_access(id, tag, col, we, wd, be);
  endtask

  // All requesters in 'mask' raise reads at once; order must be round-robin.
  task automatic contend(logic [2:0] mask, int tag);
    logic [2:0] pend = mask;
    @(negedge clk);
    for (int i = 0; i < NR; i++) if (mask[i]) begin
      req_addr[i*AW +: AW] = AW'(mk_addr(tag, 10 + i));
      req_we[i] = 1'b0;
      req_valid[i] = 1'b1;
    end
    while (pend != 0) begin
      int e = m_last, w = 0;
      for (int k = 1; k <= NR; k++) if (pend[(m_last + k) % NR]) begin
        e = (m_last + k) % NR; break;
      end
      while (req_ready == '0 && w < 40) begin @(negedge clk); w++; end
      chk(req_ready == 3'(1 << e), "R2 grant order", req_ready, 3'(1 << e));
      chk(req_ready != '0 && rsp_rdata == mem_m[tag*WORDS + 10 + e], "R2 contention data",
          rsp_rdata, mem_m[tag*WORDS + 10 + e]);
      if (req_ready == '0) break;
      for (int i = 0; i < NR; i++) if (req_ready[i]) begin
        pend[i] = 1'b0;
        model_access(i, tag, 10 + i, 1'b0, '0, '0);
        m_last = i;
      end
      @(negedge clk);
      for (int i = 0; i < NR; i++) if (!pend[i]) req_valid[i] = 1'b0;
    end
    req_valid = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < ROWS*WORDS; i++) mem_m[i] = '0;
    m_vld[0] = 0; m_vld[1] = 0; m_dirty[0] = 0; m_dirty[1] = 0;
    m_tag[0] = 0; m_tag[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == '0 && !rsp_valid, "R1 idle after reset", {req_ready, rsp_valid}, 0);

    // R2: first contention after reset starts at requester 0
    contend(3'b111, 0);
    // R8 / R4: tag 0 sits in buffer 0, next miss fills buffer 1
    single(1, 1, 3, 1'b0, '0, '0, "R4 clean miss into buffer 1");
    single(2, 0, 5, 1'b1, 32'hA5A5_1234, 4'b1111, "R3 write hit");
    single(0, 0, 5, 1'b1, 32'hFFFF_FFFF, 4'b0101, "R7 partial write hit");
    single(0, 0, 5, 1'b0, '0, '0, "R3 read hit after merge");
    // R8: LRU is buffer 1 (tag 1, clean) -> 8 cycles
    single(1, 2, 7, 1'b0, '0, '0, "R8 replace LRU clean");
    // R5: LRU now buffer 0 (tag 0, dirty) -> 12 cycles
    single(2, 3, 7, 1'b0, '0, '0, "R5 dirty victim miss");
    single(0, 0, 5, 1'b0, '0, '0, "R5 written-back data survives");
    contend(3'b101, 0);
    contend(3'b011, 3);

    for (int n = 0; n < 300; n++) begin
      int id = $urandom % NR;
      int tg = $urandom % ROWS;
      int cl = $urandom % WORDS;
      bit we = $urandom % 2;
      single(id, tg, cl, we, $urandom, 4'($urandom), we ? "R3 random write" : "R4 random read");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule